// File: doc/BRIEF.md
# Hardwired Control Step Sequencer

This block sets the timing of a hardwired CPU control unit. A small step counter walks through the control steps of one instruction. It moves forward on each clock edge while the run qualifier is high, and it stops in place while the qualifier is low, for example while memory is still busy. When the end-of-instruction input is high, the counter returns to its first step on the next edge, so the next instruction fetch can begin. The counter value is decoded into one-hot step strobes. The opcode held in the instruction register is decoded into one-hot instruction lines.

A downstream encoder combines the strobes, the instruction lines and the flags into the actual control signals. That encoder is not part of this block. Both output vectors are registered. The step strobes are decoded from the counter's next value, so they change on the same edge as the counter. The instruction lines follow the opcode one clock later. The default build has seven steps, a three-bit counter and a three-bit opcode.

Top module: `ctl_step_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the counter is cleared. From the next cycle `step_t` equals 1 (only T1, bit 0) and `instr_line` equals 0.
- R2: When `run_en` is 1 and `end_step` is 0 at an edge, and the counter holds a step value below `NUM_STEPS`, the counter increments by one. The strobe moves from bit k to bit k+1, or to no bit when k+1 reaches `NUM_STEPS`.
- R3: When `run_en` and `end_step` are both 0 at an edge, the counter and `step_t` keep their values.
- R4: When `end_step` is 1 at an edge, the next cycle shows only T1 (`step_t` equals 1), whatever the value of `run_en`. END has priority over the run qualifier.
- R5: A counter value at or above `NUM_STEPS` drives no strobe (`step_t` equals 0). The next edge with `run_en` high and `end_step` low returns the counter to 0 (T1).
- R6: Out of reset, `step_t` has exactly one bit set while the counter is below `NUM_STEPS`, and no bit set otherwise.
- R7: One cycle after an edge outside reset, `instr_line` has only bit `opcode` set, where `opcode` is the value sampled at that edge (bit i set for opcode value i).
- R8: After any edge outside reset, `instr_line` has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Run qualifier: advance when 1, hold when 0 |
| end_step | input | 1 | End of instruction: return to T1 on the next edge |
| opcode | input | OPC_W (3) | Opcode field from the instruction register |
| step_t | output | NUM_STEPS (7) | Registered one-hot step strobes; bit 0 is T1 |
| instr_line | output | 2**OPC_W (8) | Registered one-hot instruction lines |

## Verification
The end-of-instruction clear and the run qualifier can both act on the same edge. The hardest case is END high while run is low: the hold and the clear then ask for different next values, and the clear must win. The bench provokes this by walking the counter to every value from 0 to 7, including the unused value, and applying every combination of run, END and opcode there. It then judges the strobe that follows against a model: clear if END, else hold if run is low, else increment with wrap. The same sweep checks the instruction lines, because each opcode value is applied in every step.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

  // Action the step counter takes at the coming edge.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_ADV   = 2'd1,
    ACT_WRAP  = 2'd2,
    ACT_CLEAR = 2'd3
  } step_act_e;

  // Counter width needed to index a given number of steps.
  function automatic int step_cnt_width(input int n_steps);
    return (n_steps < 2) ? 1 : $clog2(n_steps);
  endfunction

endpackage

// File: rtl/ctl_onehot_dec.sv
module ctl_onehot_dec #(
  parameter int IN_W  = 3,
  parameter int OUT_N = 8
) (
  input  logic [IN_W-1:0]  sel,
  output logic [OUT_N-1:0] lines
);

  // One comparator per output; codes with no output line are dropped.
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign lines[i] = (sel == IN_W'(i));
  end

endmodule

// File: rtl/ctl_step_counter.sv
module ctl_step_counter
  import ctl_seq_pkg::*;
#(
  parameter int NUM_STEPS = 7,
  parameter int CNT_W     = step_cnt_width(NUM_STEPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             end_step,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);

  step_act_e act;
  logic      out_of_range;

  assign out_of_range = (int'(cnt_q) >= NUM_STEPS);

  // END outranks the run qualifier; run acts as a clock enable.
  always_comb begin
    if (end_step)          act = ACT_CLEAR;
    else if (!run_en)      act = ACT_HOLD;
    else if (out_of_range) act = ACT_WRAP;
    else                   act = ACT_ADV;
  end

  always_comb begin
    unique case (act)
      ACT_CLEAR: cnt_d = '0;
      ACT_WRAP:  cnt_d = '0;
      ACT_ADV:   cnt_d = cnt_q + CNT_W'(1);
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R2: an enabled edge inside the step range increments by one
  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (run_en && !end_step && !out_of_range) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R3: no run, no END: the count is frozen
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !end_step) |=> $stable(cnt_q));

  // R5: an unused value returns to zero on the next enabled edge
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (run_en && !end_step && out_of_range) |=> (cnt_q == '0));

endmodule

// File: rtl/ctl_step_seq.sv
module ctl_step_seq
  import ctl_seq_pkg::*;
#(
  parameter int NUM_STEPS = 7,
  parameter int OPC_W     = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run_en,
  input  logic                  end_step,
  input  logic [OPC_W-1:0]      opcode,
  output logic [NUM_STEPS-1:0]  step_t,
  output logic [2**OPC_W-1:0]   instr_line
);

  localparam int CNT_W   = step_cnt_width(NUM_STEPS);
  localparam int INSTR_N = 2 ** OPC_W;
  localparam logic [NUM_STEPS-1:0] T1_ONLY   = NUM_STEPS'(1);
  localparam logic [INSTR_N-1:0]   ONE_INSTR = INSTR_N'(1);

  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     cnt_d;
  logic [NUM_STEPS-1:0] step_dec;
  logic [INSTR_N-1:0]   instr_dec;

  ctl_step_counter #(
    .NUM_STEPS (NUM_STEPS),
    .CNT_W     (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .end_step (end_step),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d)
  );

  // Decode the next count so the registered strobe lines up with the counter.
  ctl_onehot_dec #(
    .IN_W  (CNT_W),
    .OUT_N (NUM_STEPS)
  ) u_step_dec (
    .sel   (cnt_d),
    .lines (step_dec)
  );

  ctl_onehot_dec #(
    .IN_W  (OPC_W),
    .OUT_N (INSTR_N)
  ) u_instr_dec (
    .sel   (opcode),
    .lines (instr_dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step_t     <= T1_ONLY;
      instr_line <= '0;
    end else begin
      step_t     <= step_dec;
      instr_line <= instr_dec;
    end
  end

  // R1: reset leaves only T1 and no instruction line
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (step_t == T1_ONLY && instr_line == '0));

  // R4: END clears to T1 even with run low
  p_end_to_t1_r4: assert property (@(posedge clk) disable iff (rst)
    end_step |=> (step_t == T1_ONLY));

  // R3: held counter means held strobes
  p_strobe_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !end_step) |=> $stable(step_t));

  // R6: one strobe inside the range, none outside it
  p_strobe_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt_q) < NUM_STEPS) ? $onehot(step_t) : (step_t == '0));

  // R7: instruction line follows the sampled opcode
  p_instr_match_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (instr_line == (ONE_INSTR << $past(opcode))));

  // R8: exactly one instruction line after a live edge
  p_instr_onehot_r8: assert property (@(posedge clk)
    !rst |=> $onehot(instr_line));

endmodule

// File: tb/ctl_step_seq_test.sv
module ctl_step_seq_test;

  localparam int NSTEP = 7;
  localparam int OPW   = 3;
  localparam int NINS  = 2 ** OPW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             run_en = 1'b0;
  logic             end_step = 1'b0;
  logic [OPW-1:0]   opcode = '0;
  logic [NSTEP-1:0] step_t;
  logic [NINS-1:0]  instr_line;

  int n_vec  = 0;
  int n_fail = 0;
  int cnt_m  = 0;
  int opc_m  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ctl_step_seq #(.NUM_STEPS(NSTEP), .OPC_W(OPW)) uut (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .end_step   (end_step),
    .opcode     (opcode),
    .step_t     (step_t),
    .instr_line (instr_line)
  );

  function automatic logic [NSTEP-1:0] exp_strobe(input int c);
    return (c < NSTEP) ? (NSTEP'(1) << c) : '0;
  endfunction

  task automatic check_vec(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Apply one cycle of inputs, update the model, check after the edge.
  task automatic cycle(input bit r, input bit run, input bit en, input int op);
    string rq;
    @(negedge clk);
    rst = r; run_en = run; end_step = en; opcode = OPW'(op);
    if (r)             begin cnt_m = 0; rq = "R1"; end
    else if (en)       begin cnt_m = 0; rq = "R4"; end
    else if (!run)     rq = "R3";
    else if (cnt_m >= NSTEP) begin cnt_m = 0; rq = "R5"; end
    else               begin cnt_m = cnt_m + 1; rq = (cnt_m >= NSTEP) ? "R5" : "R2"; end
    @(posedge clk);
    #1;
    check_vec(rq, 32'(step_t), 32'(exp_strobe(cnt_m)));
    if (r) check_vec("R1", 32'(instr_line), 32'd0);
    else begin
      check_vec("R7", 32'(instr_line), 32'(NINS'(1) << op));
      check_vec("R8", 32'($countones(instr_line)), 32'd1);
    end
    if (!r && cnt_m < NSTEP) check_vec("R6", 32'($countones(step_t)), 32'd1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    // R1 reset state
    cycle(1, 0, 0, 0);
    cycle(1, 1, 0, 5);
    // R2/R5 free run through all steps twice
    for (int k = 0; k < 18; k++) cycle(0, 1, 0, k % NINS);
    // Exhaustive: every counter value x run x END x opcode
    for (int c = 0; c < 8; c++) begin
      for (int v = 0; v < 4 * NINS; v++) begin
        cycle(1, 0, 0, 0);
        for (int a = 0; a < c; a++) cycle(0, 1, 0, a);
        cycle(0, v[0], v[1], v >> 2);   // R4 priority when v[1] set and v[0] clear
        cycle(0, 0, 0, v % NINS);      // R3 hold after the vector
      end
    end
    // Pseudo-random mix
    lfsr = 8'hA5;
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cycle(lfsr[7:5] == 3'd0, lfsr[0] | lfsr[1], lfsr[2] & lfsr[3] & lfsr[4], int'(lfsr[6:4]));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule